// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by following a four-level radix tree of 512-entry translation tables in memory. A requester gives a virtual address and the base of the top-level table through a valid/ready handshake. The walker then reads one 64-bit table entry per level over a simple memory read port. That port has a request handshake and a response handshake. The walk ends with a physical address, a page-size code and the combined permission flags. If the walk cannot complete, it ends instead with a fault cause and the level at which the fault was found.

A walk can stop early at the third level, giving a 1 GB page, or at the second level, giving a 2 MB page, when the page-size flag of the entry read there is set. Otherwise all four levels are read and the result is a 4 KB page. Only one walk is in flight at a time. A parameter sets how many physical address bits the system supports. Entries that point above that limit are rejected.

Top module: `ptw_walker`

## Requirements
- R1: A virtual address whose bits 63..48 are not all equal to bit 47 ends with fault code 1 and level 0. No memory read is issued for it.
- R2: Each entry read targets table base × 4096 + index × 8. The top-level base comes from `root_base` with its low 12 bits ignored. Each lower-level base comes from bits PA_W-1..12 of the previous entry. Indices come from VA bits 47..39, 38..30, 29..21 and 20..12 at levels 4, 3, 2 and 1. A read request stays asserted with a stable address until it is accepted.
- R3: A walk reaching level 1 makes exactly four reads. It returns size code 0 and the address {level-1 entry bits 51..12, VA bits 11..0}. Bit 7 of a level-1 entry does not change this.
- R4: A level-2 entry with bit 7 set ends the walk after three reads. It returns size code 1 and the address {entry bits 51..21, VA bits 20..0}.
- R5: A level-3 entry with bit 7 set ends the walk after two reads. It returns size code 2 and the address {entry bits 51..30, VA bits 29..0}.
- R6: An entry with bit 0 clear stops the walk at once with fault code 2 and that entry's level (4..1). Not-present takes priority over every reserved-bit condition.
- R7: Fault code 3 with the entry's level is reported in three cases: a level-4 entry with bit 7 set; a 2 MB entry with any of bits 20..13 set; a 1 GB entry with any of bits 29..13 set. Bit 12 (attribute index) of a large-page entry is never reserved.
- R8: Any entry bit in the range 51..PA_W that is set gives fault code 3 at that entry's level.
- R9: On a successful walk, `rsp_rw` is the AND of bit 1 of every entry read and `rsp_us` is the AND of bit 2. `rsp_nx` is the OR of bit 63.
- R10: `req_ready` is high only while no walk is in progress. A result stays valid and unchanged until `rsp_ready` accepts it. The fault field reads 0 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 64 | Virtual address to translate |
| root_base | input | PA_W | Top-level table address (low 12 bits ignored) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_pa | output | PA_W | Physical address |
| rsp_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rsp_fault | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 reserved bit |
| rsp_level | output | 3 | Level of the faulting entry (0 for non-canonical) |
| rsp_rw | output | 1 | Combined write permission |
| rsp_us | output | 1 | Combined user permission |
| rsp_nx | output | 1 | Combined no-execute |

## Verification
Random walks of every page size are mixed with injected faults. The bench counts every read and compares each read address against a model of the tree. A walker that mixed up the index fields, or dropped the page-size stop, would read the wrong entry or make the wrong number of reads. An absent entry that also carries reserved bits catches a design that ranks the reserved-bit fault above not-present. Large-page entries with the attribute-index bit set catch a reserved mask that is one bit too wide. Level-1 entries with bit 7 set catch a walker that treats that bit as a page-size flag. The instance runs with a 48-bit physical width and entries with bit 50 set, which shows whether the address-limit check is missing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_W   = 64;
  localparam int ADDR_ARCH = 52;
  localparam int PG_SHIFT  = 12;
  localparam int IDX_W     = 9;
  localparam int LEVELS    = 4;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_RW      = 1;
  localparam int BIT_US      = 2;
  localparam int BIT_PS      = 7;
  localparam int BIT_NX      = 63;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NONCANON = 2'd1,
    FLT_ABSENT   = 2'd2,
    FLT_RSVD     = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pgsz_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split
  import ptw_pkg::*;
#(
  parameter int N_LVL = LEVELS,
  parameter int IW    = IDX_W,
  parameter int SHIFT = PG_SHIFT
) (
  input  logic [63:0]   va,
  input  logic [2:0]    lvl,
  output logic          canonical,
  output logic [IW-1:0] idx
);
  localparam int SIGN_BIT = SHIFT + IW * N_LVL - 1;

  logic [IW-1:0] idx_tab [N_LVL];

  assign canonical = (&va[63:SIGN_BIT]) | ~(|va[63:SIGN_BIT]);

  for (genvar g = 0; g < N_LVL; g++) begin : g_idx
    assign idx_tab[g] = va[SHIFT + IW*g +: IW];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < N_LVL; k++) begin
      if (int'(lvl) == k + 1) idx = idx_tab[k];
    end
  end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int PA_W = ADDR_ARCH
) (
  input  logic [63:0]      entry,
  input  logic [2:0]       lvl,
  input  logic [29:0]      va_off,
  output logic             present,
  output logic             rsvd,
  output logic             leaf,
  output logic [1:0]       size,
  output logic [PA_W-13:0] next_base,
  output logic [PA_W-1:0]  leaf_pa
);
  localparam int BASE_W = PA_W - PG_SHIFT;

  logic        hi_bad;
  logic        lg_rsvd;
  logic [51:0] pa_full;

  if (PA_W < ADDR_ARCH) begin : g_limit
    assign hi_bad = |entry[ADDR_ARCH-1:PA_W];
  end else begin : g_full
    assign hi_bad = 1'b0;
  end

  assign present   = entry[BIT_PRESENT];
  assign next_base = entry[PG_SHIFT +: BASE_W];

  always_comb begin
    leaf    = 1'b0;
    size    = PG_4K;
    lg_rsvd = 1'b0;
    case (lvl)
      3'd1: leaf = 1'b1;
      3'd2: if (entry[BIT_PS]) begin
        leaf    = 1'b1;
        size    = PG_2M;
        lg_rsvd = |entry[20:13];
      end
      3'd3: if (entry[BIT_PS]) begin
        leaf    = 1'b1;
        size    = PG_1G;
        lg_rsvd = |entry[29:13];
      end
      3'd4: lg_rsvd = entry[BIT_PS];
      default: lg_rsvd = 1'b1;
    endcase
  end

  assign rsvd = hi_bad | lg_rsvd;

  always_comb begin
    case (size)
      PG_2M:   pa_full = {entry[51:21], va_off[20:0]};
      PG_1G:   pa_full = {entry[51:30], va_off[29:0]};
      default: pa_full = {entry[51:12], va_off[11:0]};
    endcase
  end

  assign leaf_pa = pa_full[PA_W-1:0];
endmodule

// File: rtl/ptw_perm_acc.sv
module ptw_perm_acc (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load,
  input  logic e_rw,
  input  logic e_us,
  input  logic e_nx,
  output logic rw,
  output logic us,
  output logic nx
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rw <= 1'b1;
      us <= 1'b1;
      nx <= 1'b0;
    end else if (load) begin
      rw <= rw & e_rw;
      us <= us & e_us;
      nx <= nx | e_nx;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_va,
  input  logic [PA_W-1:0] root_base,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_size,
  output logic [1:0]      rsp_fault,
  output logic [2:0]      rsp_level,
  output logic            rsp_rw,
  output logic            rsp_us,
  output logic            rsp_nx
);
  localparam int BASE_W = PA_W - PG_SHIFT;

  walk_st_e          st;
  logic [63:0]       va_q;
  logic [BASE_W-1:0] base_q;
  logic [2:0]        lvl_q;

  logic              canon;
  logic [IDX_W-1:0]  idx;
  logic              e_present, e_rsvd, e_leaf;
  logic [1:0]        e_size;
  logic [BASE_W-1:0] e_next;
  logic [PA_W-1:0]   e_pa;
  logic              take_rsp, acc_load;

  ptw_va_split u_split (
    .va        (va_q),
    .lvl       (lvl_q),
    .canonical (canon),
    .idx       (idx)
  );

  ptw_entry_check #(.PA_W(PA_W)) u_check (
    .entry     (mem_rsp_data),
    .lvl       (lvl_q),
    .va_off    (va_q[29:0]),
    .present   (e_present),
    .rsvd      (e_rsvd),
    .leaf      (e_leaf),
    .size      (e_size),
    .next_base (e_next),
    .leaf_pa   (e_pa)
  );

  assign take_rsp = (st == ST_WAIT) && mem_rsp_valid;
  assign acc_load = take_rsp && e_present && !e_rsvd;

  ptw_perm_acc u_perm (
    .clk   (clk),
    .rst   (rst),
    .clear (st == ST_CHK),
    .load  (acc_load),
    .e_rw  (mem_rsp_data[BIT_RW]),
    .e_us  (mem_rsp_data[BIT_US]),
    .e_nx  (mem_rsp_data[BIT_NX]),
    .rw    (rsp_rw),
    .us    (rsp_us),
    .nx    (rsp_nx)
  );

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);
  assign mem_rsp_ready = (st == ST_WAIT);
  assign rsp_valid     = (st == ST_DONE);
  assign mem_req_addr  = {base_q, idx, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      lvl_q     <= '0;
      rsp_pa    <= '0;
      rsp_size  <= PG_4K;
      rsp_fault <= FLT_NONE;
      rsp_level <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= root_base[PA_W-1:PG_SHIFT];
          st     <= ST_CHK;
        end
        ST_CHK: begin
          rsp_pa    <= '0;
          rsp_size  <= PG_4K;
          rsp_fault <= FLT_NONE;
          rsp_level <= '0;
          if (!canon) begin
            rsp_fault <= FLT_NONCANON;
            st        <= ST_DONE;
          end else begin
            lvl_q <= 3'(LEVELS);
            st    <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!e_present) begin
            rsp_fault <= FLT_ABSENT;
            rsp_level <= lvl_q;
            st        <= ST_DONE;
          end else if (e_rsvd) begin
            rsp_fault <= FLT_RSVD;
            rsp_level <= lvl_q;
            st        <= ST_DONE;
          end else if (e_leaf) begin
            rsp_pa    <= e_pa;
            rsp_size  <= e_size;
            rsp_level <= lvl_q;
            st        <= ST_DONE;
          end else begin
            base_q <= e_next;
            lvl_q  <= lvl_q - 3'd1;
            st     <= ST_REQ;
          end
        end
        ST_DONE: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [2:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (rst || (req_valid && req_ready)) rd_cnt <= '0;
    else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 3'd1;
  end

  p_noncanon_noread_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault == FLT_NONCANON |-> rd_cnt == 3'd0);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  p_addr_align_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[2:0] == 3'd0);
  p_4k_reads_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault == FLT_NONE && rsp_size == PG_4K |-> rd_cnt == 3'd4);
  p_2m_reads_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault == FLT_NONE && rsp_size == PG_2M |-> rd_cnt == 3'd3);
  p_1g_reads_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault == FLT_NONE && rsp_size == PG_1G |-> rd_cnt == 3'd2);
  p_absent_stop_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault == FLT_ABSENT |-> rd_cnt == 3'd5 - rsp_level);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  localparam int PAW = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic            req_valid, req_ready, mem_req_valid, mem_req_ready;
  logic [63:0]     req_va, mem_rsp_data;
  logic [PAW-1:0]  root_base, mem_req_addr, rsp_pa;
  logic            mem_rsp_valid, mem_rsp_ready, rsp_valid, rsp_ready;
  logic [1:0]      rsp_size, rsp_fault;
  logic [2:0]      rsp_level;
  logic            rsp_rw, rsp_us, rsp_nx;

  ptw_walker #(.PA_W(PAW)) u0 (.*);

  int checks = 0, errors = 0, rd_n = 0;
  bit done = 0;
  logic [51:0] cap [8];
  logic [63:0] mem [logic [51:0]];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [51:0] rnd_base();
    logic [51:0] b = rnd64()[51:0];
    b[51:PAW] = '0;
    b[11:0] = '0;
    return b;
  endfunction

  // memory model
  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [51:0] a;
        repeat ($urandom % 3) @(negedge clk);
        mem_req_ready = 1;
        a = 52'(mem_req_addr);
        if (rd_n < 8) cap[rd_n] = a;
        rd_n++;
        @(negedge clk);
        mem_req_ready = 0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_data = mem.exists(a) ? mem[a] : 64'd0;
        mem_rsp_valid = 1;
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  // kind: 0 4K, 1 2M, 2 1G, 3 non-canonical, 4 absent, 5 L4 bit7,
  //       6 2M reserved, 7 1G reserved, 8 address above width
  task automatic walk(input int kind);
    logic [63:0] va, e [1:4];
    logic [51:0] b [1:4], ea [1:4], pa;
    int leaf, stop, flt, inj, nrd;
    logic rw, us, nx;
    mem.delete();
    va = rnd64();
    va[63:48] = {16{va[47]}};
    if (kind == 3) va[63:48] = va[63:48] ^ 16'(1 << ($urandom % 16));
    leaf = (kind == 1 || kind == 6) ? 2 : (kind == 2 || kind == 7) ? 3 : 1;
    inj = 1 + $urandom % 4;
    for (int l = 1; l <= 4; l++) b[l] = rnd_base() | (52'(l) << 12);
    for (int l = 4; l >= leaf; l--) begin
      logic [63:0] x = rnd64();
      x[0] = 1'b1;
      x[1] = ($urandom % 4) != 0;
      x[2] = ($urandom % 4) != 0;
      x[62:52] = '0;
      if (l > leaf) begin
        x[7] = 1'b0;
        x[51:12] = b[l-1][51:12];
      end else if (leaf == 1) begin
        x[51:12] = rnd_base()[51:12];  // bit 7 stays random
      end else begin
        x[7] = 1'b1;
        x[51:13] = {rnd_base()[51:30], 17'd0};
        if (leaf == 2) x[29:21] = 9'($urandom);
        x[12] = $urandom % 2;
      end
      e[l] = x;
      ea[l] = {b[l][51:12], 12'd0} + {va[12 + 9*(l-1) +: 9], 3'd0};
    end
    stop = leaf; flt = 0;
    case (kind)
      3: begin flt = 1; stop = 5; end
      4: begin
        stop = inj; flt = 2; e[inj][0] = 1'b0;
        if ($urandom % 2) e[inj][50] = 1'b1;
        if (inj == 4) e[4][7] = 1'b1;
      end
      5: begin stop = 4; flt = 3; e[4][7] = 1'b1; end
      6: begin flt = 3; e[2][13 + $urandom % 8] = 1'b1; end
      7: begin flt = 3; e[3][13 + $urandom % 17] = 1'b1; end
      8: begin stop = inj; flt = 3; e[inj][PAW + $urandom % (52 - PAW)] = 1'b1; end
      default: ;
    endcase
    nrd = 5 - stop;
    for (int l = 4; l >= leaf; l--) mem[ea[l]] = e[l];
    rw = 1; us = 1; nx = 0;
    for (int l = 4; l >= stop && l >= 1; l--) begin
      rw &= e[l][1]; us &= e[l][2]; nx |= e[l][63];
    end
    case (leaf)
      2: pa = {e[2][51:21], va[20:0]};
      3: pa = {e[3][51:30], va[29:0]};
      default: pa = {e[1][51:12], va[11:0]};
    endcase
    rd_n = 0;
    @(negedge clk);
    req_va = va;
    root_base = b[4][PAW-1:0] | PAW'($urandom % 4096);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R10 busy", 64'(req_ready), 0);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_fault == 2'(flt), "R1/R6/R7/R8 fault", 64'(rsp_fault), 64'(flt));
    chk(rsp_level == 3'(flt == 1 ? 0 : stop), "R6/R7 level", 64'(rsp_level), 64'(stop));
    chk(rd_n == nrd, "R1/R3/R4/R5 reads", 64'(rd_n), 64'(nrd));
    for (int l = 4; l >= 5 - (rd_n < nrd ? rd_n : nrd) && l >= 1; l--)
      chk(cap[4-l][PAW-1:0] == ea[l][PAW-1:0], "R2 entry address", 64'(cap[4-l]), 64'(ea[l]));
    if (flt == 0) begin
      chk(rsp_pa == pa[PAW-1:0], "R3/R4/R5 pa", 64'(rsp_pa), 64'(pa[PAW-1:0]));
      chk(rsp_size == 2'(leaf - 1), "R3/R4/R5 size", 64'(rsp_size), 64'(leaf - 1));
      chk({rsp_rw, rsp_us, rsp_nx} == {rw, us, nx}, "R9 flags",
          64'({rsp_rw, rsp_us, rsp_nx}), 64'({rw, us, nx}));
    end
    begin
      logic [PAW-1:0] held = rsp_pa;
      logic [1:0] hf = rsp_fault;
      repeat (1 + $urandom % 2) @(negedge clk);
      chk(rsp_valid && rsp_pa == held && rsp_fault == hf, "R10 hold", 64'(rsp_pa), 64'(held));
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(rsp_valid == 0 && req_ready == 1, "R10 release", 64'({rsp_valid, req_ready}), 64'b01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7311));
    req_valid = 0; req_va = '0; root_base = '0; rsp_ready = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R10 reset state",
        64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 9; k++) walk(k);
    for (int n = 0; n < 150; n++) walk($urandom % 9);
    finish_run();
  end
endmodule